// File: doc/BRIEF.md
# Dual-role SPI serial port

This block is a serial port whose five pins are reassigned by a 4-bit mode field so that the port works as an SPI master or as an SPI slave. Frames are 8 bits long and are sent most significant bit first. Both roles use clock polarity 0 and phase 0: data is sampled on the rising SCK edge and changed on the falling edge. As master, the port generates SCK from the system clock and drives one active-low slave select on the RTS pin. As slave, it takes SCK and its select from pins and brings them into the system clock domain through two-flop synchronisers.

Software reaches the port through a byte-wide register bus. Writes take effect at the clock edge where `wr_en_i` is high. Reads are combinational on `addr_i`, and the side effect of a read happens at the edge where `rd_en_i` is high. The register addresses are: 0 mode, 1 control, 2 transmit data, 3 receive data, 4 status and 5 clock divider.

The transmit and receive paths each have a one-byte holding register. Ready flags and a sticky overrun flag report their state. Whenever the mode changes, both paths are locked until software has issued a soft reset to each of them. The first mode write after a hardware reset is exempt from this lock.

Top module: `spi_usart_port`

## Requirements
- R1: A mode field value of 0xE selects master and 0xF selects slave. With any other value, `txd_oe_o`, `sck_oe_o` and `rts_oe_o` are all 0, and after reset the mode field is 0.
- R2: In master mode all three output enables are 1. `txd_o` carries MOSI, `sck_o` carries the generated clock and `rts_o` carries the active-low select. MISO is sampled from `rxd_i`, and the received byte is readable at address 3.
- R3: In slave mode `sck_oe_o` and `rts_oe_o` are 0. MOSI is read from `rxd_i`, SCK from `sck_i` and the select from `cts_i` (low means selected). The MISO bits appear on `txd_o`.
- R4: As master, the select goes low exactly 2*H system cycles before the first rising SCK edge, and it rises exactly 2*H cycles after the last falling edge, where H is the divider value.
- R5: As master, each frame has exactly 8 SCK pulses, each high for H cycles and low for H cycles. The byte is sent MSB first, `txd_o` changes only on falling edges, and `rxd_i` is sampled on rising edges.
- R6: As slave, `txd_o` is driven (`txd_oe_o`=1) only while the synchronised select is low. SCK activity while the select is high receives nothing.
- R7: Status bit 3 is the reset-pending flag. A mode write that changes the mode, other than the first mode write after reset, sets this flag. While the flag is set no frame runs. Control bit 0 resets the transmit path and bit 1 resets the receive path, and the flag clears only after both paths have been reset.
- R8: A frame that completes while receive-ready is 1 sets status bit 2 (overrun) and replaces the held byte. Overrun stays set until control bit 1 is written.
- R9: Status bit 0 (transmit-ready) is 1 when the transmit holding register is empty. Status bit 1 (receive-ready) is 1 when a received byte is waiting, and a read of address 3 clears it. After reset the status reads 0x01.
- R10: The divider register at address 5 holds H. A written value below 2 is stored as 2, which keeps the SCK period at 4 or more system cycles. The reset value is 4.
- R11: As slave, when no byte is queued at the moment the select falls, the frame sends 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (applies the side effect of a read) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| txd_o | output | 1 | MOSI as master, MISO as slave |
| txd_oe_o | output | 1 | Output enable for `txd_o` |
| rxd_i | input | 1 | MISO as master, MOSI as slave |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Output enable for `sck_o` |
| rts_o | output | 1 | Active-low slave select out (master) |
| rts_oe_o | output | 1 | Output enable for `rts_o` |
| cts_i | input | 1 | Active-low slave select in (slave) |

## Verification
A wrong internal state shows up at the pins within one frame. A bit counter that is off by one changes the number of SCK pulses or shifts the byte at address 3. A wrong lead or trail counter moves the select edge by a whole number of cycles that the bench can count. A reset-pending flag that fails to set lets the select fall while the port should be locked, within a few cycles of the transmit write. A bad synchroniser or a faulty select gate is visible immediately on `txd_oe_o` and in the captured MISO byte.

// File: rtl/spi_usart_pkg.sv
package spi_usart_pkg;
  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_TX   = 3'd2;
  localparam logic [2:0] ADDR_RX   = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;
  localparam logic [2:0] ADDR_DIV  = 3'd5;

  localparam logic [3:0] MODE_MASTER = 4'hE;
  localparam logic [3:0] MODE_SLAVE  = 4'hF;

  typedef enum logic [1:0] {M_IDLE, M_LEAD, M_BITS, M_TRAIL} mst_state_e;
endpackage

// File: rtl/spi_usart_sync.sv
module spi_usart_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_usart_master.sv
module spi_usart_master
  import spi_usart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              miso_i,
  output logic              take_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              nss_o
);
  localparam int CW = HALF_W + 1;
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  mst_state_e        st_q;
  logic [CW-1:0]     hcnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic [CW-1:0]     half_c, period_c;

  assign half_c   = {1'b0, half_i} - C_ONE;
  assign period_c = {half_i, 1'b0} - C_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= M_IDLE;
      hcnt_q  <= '0;
      bit_q   <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      sck_o   <= 1'b0;
      nss_o   <= 1'b1;
      take_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      take_o <= 1'b0;
      done_o <= 1'b0;
      if (clear_i) begin
        st_q  <= M_IDLE;
        sck_o <= 1'b0;
        nss_o <= 1'b1;
      end else begin
        unique case (st_q)
          M_IDLE: if (start_i) begin
            tx_sr_q <= tx_byte_i;
            take_o  <= 1'b1;
            nss_o   <= 1'b0;
            bit_q   <= '0;
            hcnt_q  <= period_c;
            st_q    <= M_LEAD;
          end
          M_LEAD: if (hcnt_q == '0) begin
            sck_o   <= 1'b1;
            rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso_i};
            hcnt_q  <= half_c;
            st_q    <= M_BITS;
          end else hcnt_q <= hcnt_q - C_ONE;
          M_BITS: if (hcnt_q == '0) begin
            hcnt_q <= half_c;
            if (sck_o) begin
              sck_o <= 1'b0;
              if (bit_q == LAST_BIT) begin
                done_o <= 1'b1;
                hcnt_q <= period_c;
                st_q   <= M_TRAIL;
              end else begin
                bit_q   <= bit_q + BW'(1);
                tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
              end
            end else begin
              sck_o   <= 1'b1;
              rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso_i};
            end
          end else hcnt_q <= hcnt_q - C_ONE;
          M_TRAIL: if (hcnt_q == '0) begin
            nss_o <= 1'b1;
            st_q  <= M_IDLE;
          end else hcnt_q <= hcnt_q - C_ONE;
          default: st_q <= M_IDLE;
        endcase
      end
    end
  end

  assign mosi_o    = tx_sr_q[DATA_W-1];
  assign rx_byte_o = rx_sr_q;
endmodule

// File: rtl/spi_usart_slave.sv
module spi_usart_slave #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sck_s_i,
  input  logic              nss_s_i,
  input  logic              mosi_s_i,
  input  logic              tx_full_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              take_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              miso_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic              sck_d_q, nss_d_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sr_q[DATA_W-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q   <= 1'b0;
      nss_d_q   <= 1'b1;
      bit_q     <= '0;
      tx_sr_q   <= '1;
      rx_sr_q   <= '0;
      rx_byte_o <= '0;
      take_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      take_o  <= 1'b0;
      done_o  <= 1'b0;
      sck_d_q <= sck_s_i;
      nss_d_q <= nss_s_i;
      if (clear_i) begin
        bit_q   <= '0;
        tx_sr_q <= '1;
      end else if (nss_d_q && !nss_s_i) begin
        tx_sr_q <= tx_full_i ? tx_byte_i : '1;
        take_o  <= tx_full_i;
        bit_q   <= '0;
      end else if (!nss_s_i) begin
        if (sck_s_i && !sck_d_q) begin
          rx_sr_q <= rx_next;
          bit_q   <= bit_q + BW'(1);
          if (bit_q == LAST_BIT) begin
            done_o    <= 1'b1;
            rx_byte_o <= rx_next;
          end
        end else if (!sck_s_i && sck_d_q) begin
          tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b1};
        end
      end
    end
  end

  assign miso_o = tx_sr_q[DATA_W-1];
endmodule

// File: rtl/spi_usart_port.sv
module spi_usart_port
  import spi_usart_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         HALF_W     = 8,
  parameter int         SYNC_STG   = 2,
  parameter int         MIN_HALF   = 2,
  parameter int         RESET_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        txd_o,
  output logic        txd_oe_o,
  input  logic        rxd_i,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe_o,
  output logic        rts_o,
  output logic        rts_oe_o,
  input  logic        cts_i
);
  localparam logic [HALF_W-1:0] HMIN = HALF_W'(MIN_HALF);

  logic [3:0]        mode_q;
  logic [HALF_W-1:0] half_q;
  logic              cfg_seen_q, need_tx_q, need_rx_q;
  logic              tx_full_q, rx_full_q, ovr_q;
  logic [DATA_W-1:0] tx_hold_q, rx_hold_q;

  logic is_master, is_slave, blocked;
  logic wr_mode, wr_ctrl, wr_tx, wr_div, rd_rx;
  logic tx_soft_rst, rx_soft_rst;
  logic mst_clr, slv_clr;
  logic [2:0] sync_q;
  logic sck_s, nss_s, mosi_s;
  logic take_m, take_s, done_m, done_s;
  logic [DATA_W-1:0] rx_m, rx_s;
  logic mosi_m, miso_s, sck_m, nss_m;

  assign is_master   = (mode_q == MODE_MASTER);
  assign is_slave    = (mode_q == MODE_SLAVE);
  assign blocked     = need_tx_q | need_rx_q;
  assign wr_mode     = wr_en_i && addr_i == ADDR_MODE;
  assign wr_ctrl     = wr_en_i && addr_i == ADDR_CTRL;
  assign wr_tx       = wr_en_i && addr_i == ADDR_TX;
  assign wr_div      = wr_en_i && addr_i == ADDR_DIV;
  assign rd_rx       = rd_en_i && addr_i == ADDR_RX;
  assign tx_soft_rst = wr_ctrl && wdata_i[0];
  assign rx_soft_rst = wr_ctrl && wdata_i[1];
  assign mst_clr     = !is_master || blocked || tx_soft_rst || rx_soft_rst;
  assign slv_clr     = !is_slave  || blocked || tx_soft_rst || rx_soft_rst;

  spi_usart_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rxd_i, cts_i, sck_i}),
    .q_o   (sync_q)
  );
  assign {mosi_s, nss_s, sck_s} = sync_q;

  spi_usart_master #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (mst_clr),
    .half_i   (half_q),
    .start_i  (tx_full_q),
    .tx_byte_i(tx_hold_q),
    .miso_i   (rxd_i),
    .take_o   (take_m),
    .done_o   (done_m),
    .rx_byte_o(rx_m),
    .sck_o    (sck_m),
    .mosi_o   (mosi_m),
    .nss_o    (nss_m)
  );

  spi_usart_slave #(.DATA_W(DATA_W)) u_slave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (slv_clr),
    .sck_s_i  (sck_s),
    .nss_s_i  (nss_s),
    .mosi_s_i (mosi_s),
    .tx_full_i(tx_full_q),
    .tx_byte_i(tx_hold_q),
    .take_o   (take_s),
    .done_o   (done_s),
    .rx_byte_o(rx_s),
    .miso_o   (miso_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      half_q     <= HALF_W'(RESET_HALF);
      cfg_seen_q <= 1'b0;
      need_tx_q  <= 1'b0;
      need_rx_q  <= 1'b0;
      tx_full_q  <= 1'b0;
      rx_full_q  <= 1'b0;
      ovr_q      <= 1'b0;
      tx_hold_q  <= '0;
      rx_hold_q  <= '0;
    end else begin
      if (wr_mode) begin
        mode_q     <= wdata_i[3:0];
        cfg_seen_q <= 1'b1;
        if (cfg_seen_q && wdata_i[3:0] != mode_q) begin
          need_tx_q <= 1'b1;
          need_rx_q <= 1'b1;
        end
      end
      if (wr_div) half_q <= (wdata_i < HMIN) ? HMIN : wdata_i;
      // transmit path
      if (take_m || take_s) tx_full_q <= 1'b0;
      if (wr_tx) begin
        tx_hold_q <= wdata_i[DATA_W-1:0];
        tx_full_q <= 1'b1;
      end
      if (tx_soft_rst) begin
        tx_full_q <= 1'b0;
        need_tx_q <= 1'b0;
      end
      // receive path
      if (rd_rx) rx_full_q <= 1'b0;
      if (done_m || done_s) begin
        rx_hold_q <= done_m ? rx_m : rx_s;
        rx_full_q <= 1'b1;
        if (rx_full_q && !rd_rx) ovr_q <= 1'b1;
      end
      if (rx_soft_rst) begin
        rx_full_q <= 1'b0;
        ovr_q     <= 1'b0;
        need_rx_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_MODE: rdata_o = {4'b0, mode_q};
      ADDR_RX:   rdata_o = rx_hold_q;
      ADDR_STAT: rdata_o = {4'b0, blocked, ovr_q, rx_full_q, !tx_full_q};
      ADDR_DIV:  rdata_o = half_q;
      default:   rdata_o = '0;
    endcase
  end

  assign txd_o    = is_master ? mosi_m : miso_s;
  assign txd_oe_o = is_master || (is_slave && !nss_s);
  assign sck_o    = sck_m;
  assign sck_oe_o = is_master;
  assign rts_o    = is_master ? nss_m : 1'b1;
  assign rts_oe_o = is_master;
endmodule

// File: rtl/spi_usart_chk.sv
module spi_usart_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] mode_i,
  input logic       txd_oe_i,
  input logic       sck_out_i,
  input logic       sck_oe_i,
  input logic       rts_out_i,
  input logic       rts_oe_i,
  input logic       cts_in_i,
  input logic       blocked_i,
  input logic       ovr_i,
  input logic       rx_clr_i,
  input logic       mst_clr_i
);
  a_r1_idle_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 4'hE && mode_i != 4'hF) |-> (!txd_oe_i && !sck_oe_i && !rts_oe_i));

  a_r3_slave_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'hF) |-> (!sck_oe_i && !rts_oe_i));

  a_r6_miso_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'hF && $past(cts_in_i) && $past(cts_in_i, 2)) |-> !txd_oe_i);

  a_r4_select_covers_sck: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_oe_i && sck_out_i) |-> !rts_out_i);

  a_r5_sck_high_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_out_i) |=> (sck_out_i || $past(mst_clr_i)));

  a_r7_locked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_i && rts_out_i) |=> rts_out_i);

  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !rx_clr_i) |=> ovr_i);
endmodule

bind spi_usart_port spi_usart_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_q),
  .txd_oe_i (txd_oe_o),
  .sck_out_i(sck_o),
  .sck_oe_i (sck_oe_o),
  .rts_out_i(rts_o),
  .rts_oe_i (rts_oe_o),
  .cts_in_i (cts_i),
  .blocked_i(blocked),
  .ovr_i    (ovr_q),
  .rx_clr_i (rx_soft_rst),
  .mst_clr_i(mst_clr)
);

// File: tb/spi_usart_port_tb.sv
module spi_usart_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, txd_oe, rxd, sck_in = 1'b0, sck_out, sck_oe, rts, rts_oe, cts = 1'b1;

  int checks = 0, errors = 0;

  // bench-side SPI slave model for master tests
  bit         use_mst_model = 1'b1;
  logic [7:0] sl_tx = '0, cap = '0;
  logic [3:0] falls = '0;
  int         rises = 0;
  logic       mst_miso, slv_mosi = 1'b0;

  assign mst_miso = sl_tx[3'd7 - falls[2:0]];
  assign rxd = use_mst_model ? mst_miso : slv_mosi;

  always #10 clk = ~clk;

  always @(posedge sck_out) begin
    cap = {cap[6:0], txd};
    rises++;
  end
  always @(negedge sck_out) falls = falls + 4'd1;

  spi_usart_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .txd_o(txd), .txd_oe_o(txd_oe), .rxd_i(rxd),
    .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .rts_o(rts), .rts_oe_o(rts_oe), .cts_i(cts)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic mst_frame(input logic [7:0] mo, input logic [7:0] sl, input int h, input string tag);
    int lead, trail;
    logic [7:0] d;
    sl_tx = sl; rises = 0; falls = '0; cap = '0;
    lead = 0; trail = 0;
    wr(3'd2, mo);
    while (rts) @(negedge clk);
    while (!rts) begin
      if (rises == 0 && !sck_out) lead++;
      if (falls == 4'd8) trail++;
      @(negedge clk);
    end
    chk({tag, " R5 mosi byte MSB first"}, cap, mo);
    chk({tag, " R5 eight sck pulses"}, rises, 8);
    chk({tag, " R4 lead cycles"}, lead, 2 * h);
    chk({tag, " R4 trail cycles"}, trail, 2 * h);
    rd(3'd4, d);
    chk({tag, " R9 status after frame"}, d, 8'h03);
    rd(3'd3, d);
    chk({tag, " R2 miso byte"}, d, sl);
  endtask

  task automatic slv_frame(input logic [7:0] mo, output logic [7:0] mi, output logic oe_seen);
    mi = '0;
    oe_seen = 1'b1;
    cts = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      slv_mosi = mo[i];
      repeat (4) @(negedge clk);
      sck_in = 1'b1;
      mi[i] = txd;
      if (!txd_oe) oe_seen = 1'b0;
      repeat (4) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (4) @(negedge clk);
    cts = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  localparam logic [15:0] MST_VEC [4] = '{16'hA53C, 16'h0180, 16'hFF00, 16'h6E91};

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, mi;
    logic oe;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd4, d); chk("R9 reset status", d, 8'h01);
    rd(3'd0, d); chk("R1 reset mode", d, 8'h00);
    chk("R1 reset enables", {txd_oe, sck_oe, rts_oe}, 3'b000);
    rd(3'd5, d); chk("R10 reset divider", d, 8'd4);
    wr(3'd5, 8'd1);
    rd(3'd5, d); chk("R10 divider clamp", d, 8'd2);

    wr(3'd0, 8'h0E);
    rd(3'd4, d); chk("R7 first config not locked", d, 8'h01);
    chk("R2 master enables", {txd_oe, sck_oe, rts_oe}, 3'b111);

    for (int v = 0; v < 4; v++)
      mst_frame(MST_VEC[v][15:8], MST_VEC[v][7:0], 2, "vec");

    wr(3'd5, 8'd3);
    mst_frame(8'hC3, 8'h5A, 3, "div3");

    // switch to slave
    wr(3'd0, 8'h0F);
    rd(3'd4, d); chk("R7 lock after change", d, 8'h09);
    wr(3'd1, 8'h03);
    rd(3'd4, d); chk("R7 unlocked after both resets", d, 8'h01);
    use_mst_model = 1'b0;
    chk("R3 slave enables", {sck_oe, rts_oe}, 2'b00);
    chk("R6 miso idle undriven", txd_oe, 1'b0);

    wr(3'd2, 8'h96);
    slv_frame(8'h3A, mi, oe);
    chk("R3 miso byte", mi, 8'h96);
    chk("R6 miso driven while selected", oe, 1'b1);
    chk("R6 miso released", txd_oe, 1'b0);
    rd(3'd4, d); chk("R9 rx ready", d, 8'h03);
    rd(3'd3, d); chk("R3 mosi byte", d, 8'h3A);
    rd(3'd4, d); chk("R9 rx ready cleared", d, 8'h01);

    // clocking while deselected
    for (int i = 0; i < 8; i++) begin
      slv_mosi = i[0];
      repeat (4) @(negedge clk); sck_in = 1'b1;
      repeat (4) @(negedge clk); sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    rd(3'd4, d); chk("R6 deselected ignored", d, 8'h01);
    chk("R6 deselected no drive", txd_oe, 1'b0);

    slv_frame(8'hC7, mi, oe);
    chk("R11 empty sends ones", mi, 8'hFF);
    slv_frame(8'h55, mi, oe);
    rd(3'd4, d); chk("R8 overrun set", d, 8'h07);
    rd(3'd3, d); chk("R8 newest byte kept", d, 8'h55);
    rd(3'd4, d); chk("R8 overrun sticky", d, 8'h05);
    wr(3'd1, 8'h02);
    rd(3'd4, d); chk("R8 overrun cleared by rx reset", d, 8'h01);

    // back to master: locked until both resets
    use_mst_model = 1'b1;
    wr(3'd0, 8'h0E);
    rd(3'd4, d); chk("R7 lock on return", d, 8'h09);
    wr(3'd2, 8'h11);
    repeat (40) @(negedge clk);
    chk("R7 no frame while locked", rts, 1'b1);
    wr(3'd1, 8'h01);
    rd(3'd4, d); chk("R7 still locked after tx reset", d, 8'h09);
    repeat (20) @(negedge clk);
    chk("R7 still idle", rts, 1'b1);
    wr(3'd1, 8'h02);
    rd(3'd4, d); chk("R7 unlocked", d, 8'h01);
    mst_frame(8'h11, 8'hE4, 3, "unlock R7");

    wr(3'd0, 8'h03);
    chk("R1 other mode undriven", {txd_oe, sck_oe, rts_oe}, 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule